// File: doc/BRIEF.md
# Variable-Length Instruction Word Decoder

This block takes one 16-bit instruction word of a small 32-bit processor with sixteen general registers and turns it into decoded control for the rest of the pipeline. The word belongs to one of three formats: register form, register-plus-short-immediate form, or conditional branch. The top two bits of the word choose the format. The decoder pulls out the operation code, the register indices, the 8-bit immediate and the branch displacement. For a register-form word it also states whether a 32-bit extension word follows. That lets the fetch unit step either 2 or 6 bytes.

Encodings outside the defined set raise an illegal flag instead of a valid decode. A few side flags let later stages act early: a no-operation marker, a marker that a variable shift takes only five bits of its amount register, and a marker that the operation moves the stack pointer (register 1) and frame pointer (register 0) on its own. The decoder itself is combinational. The parameter `REG_OUT` can add one output register stage, and that stage freezes while `stall` is high.

Top module: `insn_format_decoder`

## Requirements
- R1: With `insn[15]`=0 the format code is 0 (register form). `decOp` carries bits [15:8], `decRegA` bits [7:4] and `decRegB` bits [3:0]. `decImm` and `decOffset` are zero.
- R2: With `insn[15:14]`=2'b10 the format code is 1 (immediate form). `decOp` carries the sub-operation bits [13:12] zero-extended (0 add, 1 subtract, 2 special-register read, 3 special-register write). `decRegA` carries bits [11:8] and `decImm` carries bits [7:0], while `decRegB` is 0. All four sub-operations are legal.
- R3: With `insn[15:14]`=2'b11 the format code is 2 (branch). `decOp` carries the condition bits [13:10] zero-extended. `decOffset` is the signed 10-bit field [9:0], sign-extended to 32 bits and doubled into a byte displacement.
- R4: `decLong` is 1 exactly for valid register-form opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38 and 0x39. It is 0 for every other word, including every immediate-form and branch word.
- R5: The legal register-form opcodes are 0x00–0x0E and 0x19–0x39, and the legal branch conditions are 0–9. Any other word with `insnValid`=1 sets `decIllegal`=1. In that case `decValid`, `decLong` and all flags and fields are 0 and the format code is 3.
- R6: `decNop` is 1 only for register-form opcode 0x00.
- R7: `decShift` is 1 only for register-form opcodes 0x27, 0x28 and 0x2D. These are the shifts that use only the low 5 bits of register B.
- R8: With `REG_OUT`=1, every output shows the decode of the word presented before the previous rising clock edge. While `stall`=1, all outputs keep their values.
- R9: While `rstN` is low, and for any word with `insnValid`=0, `decValid` and `decIllegal` are 0, the format code is 3 and all other outputs are 0.
- R10: `decStackUse` is 1 only for register-form opcodes 0x03, 0x04 and 0x19. These operations adjust the frame and stack pointers without naming them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Holds the output stage |
| insnValid | input | 1 | Instruction word present |
| insn | input | 16 | Instruction word |
| decValid | output | 1 | Legal decode present |
| decIllegal | output | 1 | Word is not a legal encoding |
| decFmt | output | 2 | 0 register, 1 immediate, 2 branch, 3 none |
| decOp | output | 8 | Opcode, sub-operation or condition |
| decRegA | output | 4 | First register index |
| decRegB | output | 4 | Second register index |
| decImm | output | 8 | Unsigned short immediate |
| decOffset | output | 32 | Branch byte displacement |
| decLong | output | 1 | 32-bit extension word follows |
| decNop | output | 1 | No-operation |
| decShift | output | 1 | Variable shift, 5-bit amount |
| decStackUse | output | 1 | Implicit frame/stack pointer update |

## Verification
The bench aims at the edges of the legal opcode ranges (0x0E/0x0F, 0x18/0x19, 0x39/0x3A). A decoder with an off-by-one range compare would let one of these words through as valid or reject a real instruction. It uses branch displacements at 0x1FF and 0x200 and conditions 9 and 10, where a missing sign extension would yield a large positive jump and a wide condition compare would accept a reserved condition. It also checks that no illegal or idle word leaks a length, flag or field. It applies stall while the word changes, where a decoder that ignores stall would show the new word too early.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int INSN_W   = 16;
  localparam int REG_W    = 4;
  localparam int OP_W     = 8;
  localparam int IMM_W    = 8;
  localparam int DISP_W   = 10;
  localparam int ADDR_W   = 32;
  localparam int COND_W   = 4;
  localparam int SUBOP_W  = 2;

  localparam logic [OP_W-1:0] OP_LO_END   = 8'h0E;
  localparam logic [OP_W-1:0] OP_HI_START = 8'h19;
  localparam logic [OP_W-1:0] OP_HI_END   = 8'h39;
  localparam logic [COND_W-1:0] COND_LAST = 4'd9;

  typedef enum logic [1:0] {
    FMT_REG  = 2'd0,
    FMT_IMM  = 2'd1,
    FMT_BR   = 2'd2,
    FMT_NONE = 2'd3
  } fmt_e;

  // strobes from control to datapath
  typedef struct packed {
    fmt_e fmt;
    logic valid;
    logic illegal;
    logic ext;
    logic nop;
    logic shift;
    logic stackUse;
  } ctl_t;

  // full decoded record
  typedef struct packed {
    fmt_e                fmt;
    logic                valid;
    logic                illegal;
    logic                ext;
    logic                nop;
    logic                shift;
    logic                stackUse;
    logic [OP_W-1:0]     op;
    logic [REG_W-1:0]    regA;
    logic [REG_W-1:0]    regB;
    logic [IMM_W-1:0]    imm;
    logic [ADDR_W-1:0]   offset;
  } dec_t;

  function automatic logic regOpLegal(input logic [OP_W-1:0] op);
    return (op <= OP_LO_END) || ((op >= OP_HI_START) && (op <= OP_HI_END));
  endfunction

  function automatic logic regOpLong(input logic [OP_W-1:0] op);
    logic r;
    unique case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
      8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22,
      8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: r = 1'b1;
      default:                                  r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic regOpShift(input logic [OP_W-1:0] op);
    return (op == 8'h27) || (op == 8'h28) || (op == 8'h2D);
  endfunction

  function automatic logic regOpStack(input logic [OP_W-1:0] op);
    return (op == 8'h03) || (op == 8'h04) || (op == 8'h19);
  endfunction

endpackage

// File: rtl/idec_control.sv
module idec_control
  import idec_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            insnValid,
  input  logic [OP_W-1:0] insnHi,
  output ctl_t            ctl
);

  localparam int TOP = OP_W - 1;

  logic isReg, isImm, isBr;
  logic [COND_W-1:0] cond;
  logic legal;

  assign isReg = ~insnHi[TOP];
  assign isImm = insnHi[TOP] & ~insnHi[TOP-1];
  assign isBr  = insnHi[TOP] &  insnHi[TOP-1];
  assign cond  = insnHi[TOP-2 -: COND_W];

  always_comb begin
    legal = 1'b0;
    if (isReg)      legal = regOpLegal(insnHi);
    else if (isImm) legal = 1'b1;
    else if (isBr)  legal = (cond <= COND_LAST);
  end

  always_comb begin
    ctl          = '0;
    ctl.fmt      = FMT_NONE;
    ctl.illegal  = insnValid & ~legal;
    ctl.valid    = insnValid & legal;
    if (insnValid && legal) begin
      if (isReg) begin
        ctl.fmt      = FMT_REG;
        ctl.ext      = regOpLong(insnHi);
        ctl.nop      = (insnHi == '0);
        ctl.shift    = regOpShift(insnHi);
        ctl.stackUse = regOpStack(insnHi);
      end else if (isImm) begin
        ctl.fmt = FMT_IMM;
      end else begin
        ctl.fmt = FMT_BR;
      end
    end
  end

  // R9: an idle slot produces neither a decode nor a fault
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !insnValid |-> (!ctl.valid && !ctl.illegal));

  // R4: only register-form words may carry an extension word
  a_r4_ext_regform: assert property (@(posedge clk) disable iff (!rstN)
    (insnValid && insnHi[TOP]) |-> !ctl.ext);

  // R5: reserved branch conditions are faulted
  a_r5_bad_cond: assert property (@(posedge clk) disable iff (!rstN)
    (insnValid && isBr && cond > COND_LAST) |-> ctl.illegal);

endmodule

// File: rtl/idec_datapath.sv
module idec_datapath
  import idec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic [INSN_W-1:0] insn,
  input  ctl_t              ctl,
  output dec_t              dec
);

  localparam int SEXT_W = ADDR_W - DISP_W - 1;

  dec_t nxt;
  dec_t idle;

  always_comb begin
    idle     = '0;
    idle.fmt = FMT_NONE;
  end

  always_comb begin
    nxt          = idle;
    nxt.illegal  = ctl.illegal;
    if (ctl.valid) begin
      nxt.fmt      = ctl.fmt;
      nxt.valid    = 1'b1;
      nxt.ext      = ctl.ext;
      nxt.nop      = ctl.nop;
      nxt.shift    = ctl.shift;
      nxt.stackUse = ctl.stackUse;
      case (ctl.fmt)
        FMT_REG: begin
          nxt.op   = insn[15:8];
          nxt.regA = insn[7:4];
          nxt.regB = insn[3:0];
        end
        FMT_IMM: begin
          nxt.op   = {{(OP_W-SUBOP_W){1'b0}}, insn[13:12]};
          nxt.regA = insn[11:8];
          nxt.imm  = insn[IMM_W-1:0];
        end
        FMT_BR: begin
          nxt.op     = {{(OP_W-COND_W){1'b0}}, insn[13:10]};
          nxt.offset = {{SEXT_W{insn[DISP_W-1]}}, insn[DISP_W-1:0], 1'b0};
        end
        default: ;
      endcase
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      dec_t q;
      always_ff @(posedge clk) begin
        if (!rstN)       q <= idle;
        else if (!stall) q <= nxt;
      end
      assign dec = q;

      // R8: a stalled stage keeps every output
      a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
        stall |=> $stable(q));
    end else begin : g_comb
      logic unusedTie;
      assign unusedTie = stall;
      assign dec = nxt;
    end
  endgenerate

  // R5: a fault never comes with a decode or a length
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    dec.illegal |-> (!dec.valid && !dec.ext && dec.fmt == FMT_NONE));

  // R4: long words are register form only
  a_r4_long_regform: assert property (@(posedge clk) disable iff (!rstN)
    dec.ext |-> (dec.valid && dec.fmt == FMT_REG));

  // R6: no-operation has opcode zero and is short
  a_r6_nop_short: assert property (@(posedge clk) disable iff (!rstN)
    dec.nop |-> (dec.op == '0 && !dec.ext));

  // R3: branch displacement is always an even byte count
  a_r3_even_disp: assert property (@(posedge clk) disable iff (!rstN)
    (dec.fmt == FMT_BR) |-> !dec.offset[0]);

  // R9: no fields without a valid decode
  a_r9_no_leak: assert property (@(posedge clk) disable iff (!rstN)
    !dec.valid |-> (dec.op == '0 && dec.regA == '0 && dec.imm == '0 && dec.offset == '0));

endmodule

// File: rtl/insn_format_decoder.sv
module insn_format_decoder
  import idec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              insnValid,
  input  logic [INSN_W-1:0] insn,
  output logic              decValid,
  output logic              decIllegal,
  output logic [1:0]        decFmt,
  output logic [OP_W-1:0]   decOp,
  output logic [REG_W-1:0]  decRegA,
  output logic [REG_W-1:0]  decRegB,
  output logic [IMM_W-1:0]  decImm,
  output logic [ADDR_W-1:0] decOffset,
  output logic              decLong,
  output logic              decNop,
  output logic              decShift,
  output logic              decStackUse
);

  ctl_t ctl;
  dec_t dec;

  idec_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .insnValid (insnValid),
    .insnHi    (insn[INSN_W-1 -: OP_W]),
    .ctl       (ctl)
  );

  idec_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stall (stall),
    .insn  (insn),
    .ctl   (ctl),
    .dec   (dec)
  );

  assign decValid    = dec.valid;
  assign decIllegal  = dec.illegal;
  assign decFmt      = dec.fmt;
  assign decOp       = dec.op;
  assign decRegA     = dec.regA;
  assign decRegB     = dec.regB;
  assign decImm      = dec.imm;
  assign decOffset   = dec.offset;
  assign decLong     = dec.ext;
  assign decNop      = dec.nop;
  assign decShift    = dec.shift;
  assign decStackUse = dec.stackUse;

endmodule

// File: tb/tb_insn_format_decoder.sv
`timescale 1ns/1ps
module tb_insn_format_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stall = 1'b0;
  logic        insnValid = 1'b0;
  logic [15:0] insn = '0;
  logic        decValid, decIllegal, decLong, decNop, decShift, decStackUse;
  logic [1:0]  decFmt;
  logic [7:0]  decOp, decImm;
  logic [3:0]  decRegA, decRegB;
  logic [31:0] decOffset;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  insn_format_decoder dut (
    .clk(clk), .rstN(rstN), .stall(stall), .insnValid(insnValid), .insn(insn),
    .decValid(decValid), .decIllegal(decIllegal), .decFmt(decFmt), .decOp(decOp),
    .decRegA(decRegA), .decRegB(decRegB), .decImm(decImm), .decOffset(decOffset),
    .decLong(decLong), .decNop(decNop), .decShift(decShift), .decStackUse(decStackUse)
  );

  typedef struct {
    logic        v, ill, lng, nop, sh, stk;
    logic [1:0]  fmt;
    logic [7:0]  op, imm;
    logic [3:0]  ra, rb;
    logic [31:0] off;
  } exp_t;

  function automatic exp_t quiet();
    exp_t e;
    e.v = 0; e.ill = 0; e.lng = 0; e.nop = 0; e.sh = 0; e.stk = 0;
    e.fmt = 2'd3; e.op = 0; e.imm = 0; e.ra = 0; e.rb = 0; e.off = 0;
    return e;
  endfunction

  // independent reference built from the requirement text
  function automatic exp_t model(input logic vld, input logic [15:0] w);
    exp_t e = quiet();
    int code;
    int c;
    int d;
    if (!vld) return e;
    if (w[15] == 1'b0) begin
      code = int'(w[15:8]);
      if (code > 14 && code < 25 || code > 57) begin e.ill = 1; return e; end
      e.v = 1; e.fmt = 0; e.op = w[15:8]; e.ra = w[7:4]; e.rb = w[3:0];
      case (code)
        1, 3, 8, 9, 12, 13, 26, 27, 29, 31, 32, 34, 36, 48, 54, 55, 56, 57: e.lng = 1;
        default: e.lng = 0;
      endcase
      e.nop = (code == 0);
      e.sh  = (code == 39 || code == 40 || code == 45);
      e.stk = (code == 3 || code == 4 || code == 25);
    end else if (w[14] == 1'b0) begin
      e.v = 1; e.fmt = 1; e.op = 8'(w[13:12]); e.ra = w[11:8]; e.imm = w[7:0];
    end else begin
      c = int'(w[13:10]);
      if (c >= 10) begin e.ill = 1; return e; end
      e.v = 1; e.fmt = 2; e.op = 8'(c);
      d = int'(w[9:0]);
      if (d >= 512) d = d - 1024;
      e.off = 32'(d * 2);
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input logic [15:0] w);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s word=%h actual=%h expected=%h", tag, w, act, exp);
    end
  endtask

  task automatic compare(input exp_t e, input logic [15:0] w, input string pre);
    chk({pre, "R1/R2/R3 fmt"}, 32'(decFmt), 32'(e.fmt), w);
    chk({pre, "R1/R2/R3 op"},  32'(decOp), 32'(e.op), w);
    chk({pre, "R1 regA"},      32'(decRegA), 32'(e.ra), w);
    chk({pre, "R1 regB"},      32'(decRegB), 32'(e.rb), w);
    chk({pre, "R2 imm"},       32'(decImm), 32'(e.imm), w);
    chk({pre, "R3 offset"},    decOffset, e.off, w);
    chk({pre, "R4 long"},      32'(decLong), 32'(e.lng), w);
    chk({pre, "R5 valid"},     32'(decValid), 32'(e.v), w);
    chk({pre, "R5 illegal"},   32'(decIllegal), 32'(e.ill), w);
    chk({pre, "R6 nop"},       32'(decNop), 32'(e.nop), w);
    chk({pre, "R7 shift"},     32'(decShift), 32'(e.sh), w);
    chk({pre, "R10 stack"},    32'(decStackUse), 32'(e.stk), w);
  endtask

  // drive on a falling edge, one rising edge captures, sample at next falling edge (R8 latency)
  task automatic apply(input logic vld, input logic [15:0] w);
    @(negedge clk);
    insnValid = vld;
    insn      = w;
    @(negedge clk);
    compare(model(vld, w), w, "");
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    exp_t held;
    void'($urandom(32'h5EED_1234));
    // R9: reset state
    insnValid = 1'b1; insn = 16'h0100;
    repeat (3) @(negedge clk);
    compare(quiet(), 16'h0100, "reset R9 ");
    rstN = 1'b1;

    // directed corners
    apply(1, 16'h0000);          // R6 nop
    apply(1, 16'h0153);          // R4 long
    apply(1, 16'h0EAB);          // R5 last low legal
    apply(1, 16'h0F12);          // R5 first hole
    apply(1, 16'h1812);          // R5 last hole
    apply(1, 16'h1934);          // R10 stack, first high legal
    apply(1, 16'h3977);          // R4 last legal, long
    apply(1, 16'h3A00);          // R5 beyond range
    apply(1, 16'h7FFF);          // R5 top of register space
    apply(1, 16'h2712);          // R7
    apply(1, 16'h28F1);          // R7
    apply(1, 16'h2D5E);          // R7
    apply(1, 16'h0312);          // R10 + R4
    apply(1, 16'h0400);          // R10 short
    apply(1, 16'h8A7F);          // R2 add
    apply(1, 16'hBFFF);          // R2 write special
    apply(1, 16'hE600);          // R3 cond 9, offset -512
    apply(1, 16'hC1FF);          // R3 offset +511
    apply(1, 16'hE800);          // R5 cond 10 illegal
    apply(1, 16'hFFFF);          // R5 cond 15 illegal
    apply(0, 16'h0F00);          // R9 idle illegal word ignored
    apply(0, 16'h0153);          // R9 idle long word ignored

    // R8: stall holds outputs while input changes
    apply(1, 16'h2A5C);
    held = model(1, 16'h2A5C);
    @(negedge clk); stall = 1'b1; insn = 16'hE600;
    @(negedge clk); compare(held, 16'h2A5C, "stall R8 ");
    @(negedge clk); compare(held, 16'h2A5C, "stall R8 ");
    stall = 1'b0;
    @(negedge clk); compare(model(1, 16'hE600), 16'hE600, "release R8 ");

    // constrained random: bias towards register form and the range edges
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      w = 16'($urandom);
      if (sel < 5) w[15] = 1'b0;
      else if (sel == 5) w[15:8] = 8'($urandom_range(8'h0C, 8'h1B));
      else if (sel == 6) w[15:8] = 8'($urandom_range(8'h36, 8'h3C));
      apply(($urandom_range(0, 15) != 0), w);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule